// File: doc/BRIEF.md
# Writable ISA Identity Decode Selector

This block holds a writable identity tuple, made of a vendor half and an architecture half, and uses it to choose which one of several instruction decode engines interprets the incoming instruction words. Each engine may stand for a base ISA revision, a custom extension set or a foreign instruction set. Software changes the meaning of the same binary encoding at run time with a single write to the identity register. The decoders themselves are outside this block. It only produces the one-hot engine select that travels with the instruction word.

The register follows write-any, read-legal rules. A write whose value matches an entry of the supported tuple table selects that engine. Any other value is dropped, and the register keeps the tuple it held before. A build-time option freezes the register at its default tuple. That option marks a part with no custom extensions, and every write to it is ignored. Changing the tuple touches nothing except the select, so the instruction word passes through untouched and state held in the engines is never disturbed.

The supported table is computed from the engine count. Engine k owns the 32-bit tuple {8'hA5, k[7:0], 8'h3C, k[7:0]}, with the vendor half in bits 31:16 and the architecture half in bits 15:0. Engine 0 is the base ISA engine.

Top module: `isa_id_decode_sel`

## Requirements
- R1: While reset is asserted and after it is released, `csr_rd_tuple` reads 32'hA500_3C00 (the engine 0 tuple) and `dec_vld` is 0.
- R2: A write on `csr_wr_en` whose `csr_wr_tuple` equals {8'hA5, k, 8'h3C, k} for some k below NUM_ENG selects engine k, and `csr_rd_tuple` returns that value from the clock edge that commits the write.
- R3: A write of any value outside the supported table, including the pattern for an engine index of NUM_ENG or more, leaves `csr_rd_tuple` and the engine selection unchanged.
- R4: `dec_vld` equals `insn_vld` delayed by one cycle, and `dec_word` equals the `insn_word` that was sampled with it.
- R5: When `dec_vld` is 1, `dec_sel` has exactly one bit set, bit k for engine k. When `dec_vld` is 0, `dec_sel` is all zero.
- R6: An instruction sampled at the same clock edge as a committing write is routed with the old selection. The next instruction is routed with the new one.
- R7: Writes on consecutive cycles each take effect for the instruction presented in the following cycle, so the engine can be switched per instruction.
- R8: With READ_ONLY set to 1, writes have no effect. `csr_rd_tuple` stays 32'hA500_3C00 and every valid instruction is routed to engine 0.
- R9: Changing the tuple does not alter the instruction word. `dec_word` always carries the word as it was presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_wr_en | input | 1 | Identity register write strobe |
| csr_wr_tuple | input | 32 | Tuple written: vendor in 31:16, architecture in 15:0 |
| csr_rd_tuple | output | 32 | Current legal tuple |
| insn_vld | input | 1 | Instruction word valid |
| insn_word | input | 32 | Instruction word |
| dec_vld | output | 1 | Registered instruction valid |
| dec_word | output | 32 | Registered instruction word |
| dec_sel | output | NUM_ENG | One-hot engine select, registered |

## Verification
The readback is due at the clock edge that commits a write. The select, valid and word outputs are due one edge after the instruction is sampled, and they use the tuple that held before that edge. The bench drives every input on the falling edge and compares all outputs one time unit after the following rising edge. Its model records the select from the old tuple first and only then applies the write, which reproduces the same-edge ordering. A second instance built as read-only receives the same stimulus and is checked at the same instant.

// File: rtl/isa_id_pkg.sv
package isa_id_pkg;

    localparam int ID_W  = 16;
    localparam int TUP_W = 2 * ID_W;

    // Engine k answers to vendor {A5, k} and architecture {3C, k}
    function automatic logic [TUP_W-1:0] tuple_of(input int k);
        logic [7:0] kb;
        kb = k[7:0];
        return {8'hA5, kb, 8'h3C, kb};
    endfunction

endpackage

// File: rtl/isa_id_match.sv
module isa_id_match
    import isa_id_pkg::*;
#(
    parameter int NUM_ENG = 4,
    localparam int IDX_W  = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1
) (
    input  logic [TUP_W-1:0]   wr_tuple,
    input  logic [IDX_W-1:0]   cur_idx,
    output logic               hit,
    output logic [IDX_W-1:0]   hit_idx,
    output logic [TUP_W-1:0]   cur_tuple,
    output logic [NUM_ENG-1:0] sel_vec
);

    logic [NUM_ENG-1:0] hit_vec;

    for (genvar k = 0; k < NUM_ENG; k++) begin : g_eng
        assign hit_vec[k] = (wr_tuple == tuple_of(k));
        assign sel_vec[k] = (cur_idx == IDX_W'(k));
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_idx   = '0;
        cur_tuple = tuple_of(0);
        for (int k = 0; k < NUM_ENG; k++) begin
            if (hit_vec[k]) hit_idx = IDX_W'(k);
            if (cur_idx == IDX_W'(k)) cur_tuple = tuple_of(k);
        end
    end

endmodule

// File: rtl/isa_id_warl_reg.sv
module isa_id_warl_reg #(
    parameter int NUM_ENG   = 4,
    parameter bit READ_ONLY = 1'b0,
    localparam int IDX_W    = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             hit,
    input  logic [IDX_W-1:0] hit_idx,
    output logic [IDX_W-1:0] idx_q
);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } warl_t;

    warl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!READ_ONLY && wr_en && hit) st_d.idx = hit_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idx_q = st_q.idx;

    a_r3_illegal_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit) |=> $stable(idx_q));

    a_r2_legal_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (!READ_ONLY && wr_en && hit) |=> (idx_q == $past(hit_idx)));

    a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (READ_ONLY && wr_en) |=> (idx_q == '0));

endmodule

// File: rtl/isa_id_route.sv
module isa_id_route #(
    parameter int NUM_ENG = 4,
    parameter int WORD_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               insn_vld,
    input  logic [WORD_W-1:0]  insn_word,
    input  logic [NUM_ENG-1:0] sel_vec,
    output logic               dec_vld,
    output logic [WORD_W-1:0]  dec_word,
    output logic [NUM_ENG-1:0] dec_sel
);

    typedef struct packed {
        logic               vld;
        logic [WORD_W-1:0]  word;
        logic [NUM_ENG-1:0] sel;
    } route_t;

    route_t rt_d, rt_q;

    always_comb begin
        rt_d     = rt_q;
        rt_d.vld = insn_vld;
        rt_d.sel = '0;
        if (insn_vld) begin
            rt_d.word = insn_word;
            rt_d.sel  = sel_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rt_q <= '0;
        else        rt_q <= rt_d;
    end

    assign dec_vld  = rt_q.vld;
    assign dec_word = rt_q.word;
    assign dec_sel  = rt_q.sel;

    a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
        insn_vld |=> (dec_vld && dec_word == $past(insn_word)));

    a_r5_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld |-> ($countones(dec_sel) == 1));

    a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_vld |-> (dec_sel == '0));

endmodule

// File: rtl/isa_id_decode_sel.sv
module isa_id_decode_sel
    import isa_id_pkg::*;
#(
    parameter int NUM_ENG   = 4,
    parameter bit READ_ONLY = 1'b0,
    parameter int WORD_W    = 32,
    localparam int IDX_W    = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csr_wr_en,
    input  logic [TUP_W-1:0]   csr_wr_tuple,
    output logic [TUP_W-1:0]   csr_rd_tuple,
    input  logic               insn_vld,
    input  logic [WORD_W-1:0]  insn_word,
    output logic               dec_vld,
    output logic [WORD_W-1:0]  dec_word,
    output logic [NUM_ENG-1:0] dec_sel
);

    logic               hit;
    logic [IDX_W-1:0]   hit_idx;
    logic [IDX_W-1:0]   idx_q;
    logic [NUM_ENG-1:0] sel_vec;

    isa_id_match #(.NUM_ENG(NUM_ENG)) u_match (
        .wr_tuple  (csr_wr_tuple),
        .cur_idx   (idx_q),
        .hit       (hit),
        .hit_idx   (hit_idx),
        .cur_tuple (csr_rd_tuple),
        .sel_vec   (sel_vec)
    );

    isa_id_warl_reg #(.NUM_ENG(NUM_ENG), .READ_ONLY(READ_ONLY)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (csr_wr_en),
        .hit     (hit),
        .hit_idx (hit_idx),
        .idx_q   (idx_q)
    );

    isa_id_route #(.NUM_ENG(NUM_ENG), .WORD_W(WORD_W)) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .insn_vld  (insn_vld),
        .insn_word (insn_word),
        .sel_vec   (sel_vec),
        .dec_vld   (dec_vld),
        .dec_word  (dec_word),
        .dec_sel   (dec_sel)
    );

    // R6: select follows the tuple that held when the word was sampled
    a_r6_old_tuple: assert property (@(posedge clk) disable iff (!rst_n)
        insn_vld |=> (dec_sel == (NUM_ENG'(1) << $past(idx_q))));

    // R1/R8: readback always belongs to the supported table
    a_r1_legal_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rd_tuple[31:24] == 8'hA5 && csr_rd_tuple[15:8] == 8'h3C));

endmodule

// File: tb/isa_id_decode_sel_tb_top.sv
module isa_id_decode_sel_tb_top;

    localparam int NUM_ENG = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr_en = 1'b0;
    logic [31:0] csr_wr_tuple = '0;
    logic        insn_vld = 1'b0;
    logic [31:0] insn_word = '0;

    logic [31:0]        rd_t, ro_rd_t, dec_word, ro_word;
    logic               dec_vld, ro_vld;
    logic [NUM_ENG-1:0] dec_sel, ro_sel;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int          m_idx = 0;
    logic [31:0] exp_word = '0;

    always #2 clk = ~clk;

    isa_id_decode_sel #(.NUM_ENG(NUM_ENG), .READ_ONLY(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .csr_wr_en(csr_wr_en), .csr_wr_tuple(csr_wr_tuple),
        .csr_rd_tuple(rd_t), .insn_vld(insn_vld), .insn_word(insn_word),
        .dec_vld(dec_vld), .dec_word(dec_word), .dec_sel(dec_sel));

    isa_id_decode_sel #(.NUM_ENG(NUM_ENG), .READ_ONLY(1'b1)) dut_ro_i (
        .clk(clk), .rst_n(rst_n), .csr_wr_en(csr_wr_en), .csr_wr_tuple(csr_wr_tuple),
        .csr_rd_tuple(ro_rd_t), .insn_vld(insn_vld), .insn_word(insn_word),
        .dec_vld(ro_vld), .dec_word(ro_word), .dec_sel(ro_sel));

    function automatic logic [31:0] tup(input int k);
        return {8'hA5, 8'(k), 8'h3C, 8'(k)};
    endfunction

    function automatic int legal_idx(input logic [31:0] t);
        for (int k = 0; k < NUM_ENG; k++) if (t == tup(k)) return k;
        return -1;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic step(input bit we, input logic [31:0] wt, input bit v,
                        input logic [31:0] w, input string tag);
        logic [31:0] exp_sel;
        int          k;
        @(negedge clk);
        csr_wr_en = we; csr_wr_tuple = wt; insn_vld = v; insn_word = w;
        exp_sel = v ? (32'd1 << m_idx) : 32'd0;
        if (v) exp_word = w;
        k = legal_idx(wt);
        if (we && k >= 0) m_idx = k;
        @(posedge clk);
        #1;
        check({"R4 valid ", tag}, {31'd0, dec_vld}, {31'd0, v});
        check({"R9 word ", tag}, dec_word, exp_word);
        check({"R5 R6 select ", tag}, 32'(dec_sel), exp_sel);
        check({"R2 R3 readback ", tag}, rd_t, tup(m_idx));
        check({"R8 ro readback ", tag}, ro_rd_t, tup(0));
        check({"R8 ro select ", tag}, 32'(ro_sel), v ? 32'd1 : 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        #1;
        check("R1 reset readback", rd_t, tup(0));
        check("R1 reset valid", {31'd0, dec_vld}, 32'd0);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 readback after release", rd_t, tup(0));

        step(1'b0, 32'd0, 1'b1, 32'h0000_0013, "R1 base engine");
        step(1'b1, tup(2), 1'b0, 32'd0, "R2 legal write");
        step(1'b0, 32'd0, 1'b1, 32'h1234_5678, "R2 engine 2");
        step(1'b1, tup(4), 1'b1, 32'hDEAD_BEEF, "R3 index out of range");
        step(1'b1, 32'hFFFF_FFFF, 1'b1, 32'hCAFE_0001, "R3 garbage");
        step(1'b1, {8'hA5, 8'h01, 8'h3C, 8'h02}, 1'b1, 32'h0, "R3 mixed halves");
        step(1'b1, tup(3), 1'b1, 32'hAAAA_5555, "R6 same edge old select");
        step(1'b0, 32'd0, 1'b1, 32'h5555_AAAA, "R6 next uses new");
        for (int k = 0; k < NUM_ENG; k++)
            step(1'b1, tup(k), 1'b1, 32'h0BAD_0000 + 32'(k), "R7 back to back");
        step(1'b0, 32'd0, 1'b0, 32'd0, "R5 idle");

        for (int i = 0; i < 400; i++) begin
            bit          we;
            logic [31:0] wt;
            we = ($urandom % 3) == 0;
            wt = (($urandom % 4) != 0) ? tup($urandom % (NUM_ENG + 2)) : 32'($urandom);
            step(we, wt, 1'($urandom), 32'($urandom), "R9 random");
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule